// File: doc/BRIEF.md
# Sequencer Step Counter with Dual-Source Clear and Hold

This block is the step counter inside a programmable sequence engine. It holds a 6-bit binary value that advances by one on each active clock edge. The product-term logic around it reads this value back to decide the next control terms. Two control functions steer the counter. Zeroing brings it back to the first step. Freezing makes it dwell on the current step. Each function is fed by two independent request lines, and the two lines are OR'd together.

Each request line has its own path select. A line can act on the very edge where it is presented, which is the direct path. It can instead be captured into a private flop on that edge and act one edge later, which is the registered path. A single configuration bit chooses whether the whole block works on the rising or the falling clock edge. Zeroing always beats freezing.

Top module: `seqgen_counter`

## Requirements
- R1: With no zero or freeze request in effect, the count rises by one on every active edge, and it wraps from 63 to 0.
- R2: When a zero request is in effect from either zero line, the count is 0 after the next active edge.
- R3: When a freeze request is in effect from either freeze line, and no zero request is in effect, the count keeps its value across the active edge.
- R4: When a zero request and a freeze request are in effect on the same edge, the count goes to 0.
- R5: A line whose select bit is 0 (direct) acts on the edge at which it is high. Whatever that line held on earlier edges has no effect.
- R6: A line whose select bit is 1 (registered) is captured on each active edge and acts on the next active edge. Its present value has no effect on the current edge.
- R7: `edge_fall` = 0 makes the rising clock edge active, and `edge_fall` = 1 makes the falling edge active. It may be changed only while `rst_n` is low.
- R8: A low level on `rst_n` clears the count and every captured request copy at once. After `rst_n` rises, the block first counts on the third active edge, because release passes through two synchronizing stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| edge_fall | input | 1 | Active-edge select: 0 rising, 1 falling |
| clr_raw | input | 2 | Zero request lines, bit per line |
| clr_use_reg | input | 2 | Per zero line: 0 direct, 1 registered |
| hold_raw | input | 2 | Freeze request lines, bit per line |
| hold_use_reg | input | 2 | Per freeze line: 0 direct, 1 registered |
| count | output | 6 | Present step count |

## Verification
The count is the only output and it is also fed back, so any wrong internal state shows on `count` after one active edge. A stale or missing request copy shows up as a freeze or zero arriving one edge early or one edge late, or applied to the wrong line. The bench therefore switches the path selects between steps and checks the count edge by edge. A reset that leaves a captured copy set is caught on the first step after release. In falling-edge mode, a count that moves on the wrong edge is caught by sampling between the two edges.

// File: rtl/seqgen_counter_pkg.sv
package seqgen_counter_pkg;
  localparam int unsigned STEP_W      = 6;
  localparam int unsigned LINES       = 2;
  localparam int unsigned SYNC_DEPTH  = 2;

  typedef enum logic {
    PATH_DIRECT     = 1'b0,
    PATH_REGISTERED = 1'b1
  } path_sel_e;
endpackage

// File: rtl/seqgen_rst_sync.sv
module seqgen_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-1:0] stage_q;
  logic [DEPTH-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[LAST];

  // release reaches the output only after a full pass through the stages (R8)
  assert_release_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> $past(stage_q[LAST-1]));
endmodule

// File: rtl/seqgen_ctl_source.sv
module seqgen_ctl_source
  import seqgen_counter_pkg::*;
#(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_raw,
  input  logic [N-1:0] req_use_reg,
  output logic         req_active
);
  logic [N-1:0] copy_q;
  logic [N-1:0] copy_d;
  logic         copy_en;
  logic [N-1:0] pick;

  always_comb begin
    copy_en = 1'b1;
    copy_d  = req_raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       copy_q <= '0;
    else if (copy_en) copy_q <= copy_d;
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    always_comb begin
      if (path_sel_e'(req_use_reg[i]) == PATH_REGISTERED) pick[i] = copy_q[i];
      else                                                 pick[i] = req_raw[i];
    end

    // registered line: value seen one edge after it was presented (R6)
    assert_copy_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_raw[i] |=> copy_q[i]);
  end

  always_comb req_active = |pick;
endmodule

// File: rtl/seqgen_count_core.sv
module seqgen_count_core #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         zero_req,
  input  logic         freeze_req,
  output logic [W-1:0] step
);
  logic [W-1:0] step_q;
  logic [W-1:0] step_d;
  logic         step_en;

  always_comb begin
    step_en = zero_req | ~freeze_req;
    if (zero_req) step_d = '0;
    else          step_d = step_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= '0;
    else if (step_en) step_q <= step_d;
  end

  assign step = step_q;

  assert_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero_req && !freeze_req) |=> (step == W'($past(step) + W'(1))));
  assert_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    zero_req |=> (step == '0));
  assert_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero_req && freeze_req) |=> $stable(step));
  assert_zero_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_req && freeze_req) |=> (step == '0));
endmodule

// File: rtl/seqgen_counter.sv
module seqgen_counter
  import seqgen_counter_pkg::*;
#(
  parameter int unsigned CNT_W   = STEP_W,
  parameter int unsigned N_LINES = LINES,
  parameter int unsigned N_SYNC  = SYNC_DEPTH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               edge_fall,
  input  logic [N_LINES-1:0] clr_raw,
  input  logic [N_LINES-1:0] clr_use_reg,
  input  logic [N_LINES-1:0] hold_raw,
  input  logic [N_LINES-1:0] hold_use_reg,
  output logic [CNT_W-1:0]   count
);
  logic act_clk;
  logic rst_int_n;
  logic zero_req;
  logic freeze_req;

  // inverting the clock turns the falling edge into the active one (R7)
  always_comb act_clk = clk ^ edge_fall;

  seqgen_rst_sync #(.DEPTH(N_SYNC)) u_rst (
    .clk        (act_clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  seqgen_ctl_source #(.N(N_LINES)) u_zero_src (
    .clk         (act_clk),
    .rst_n       (rst_int_n),
    .req_raw     (clr_raw),
    .req_use_reg (clr_use_reg),
    .req_active  (zero_req)
  );

  seqgen_ctl_source #(.N(N_LINES)) u_freeze_src (
    .clk         (act_clk),
    .rst_n       (rst_int_n),
    .req_raw     (hold_raw),
    .req_use_reg (hold_use_reg),
    .req_active  (freeze_req)
  );

  seqgen_count_core #(.W(CNT_W)) u_core (
    .clk        (act_clk),
    .rst_n      (rst_int_n),
    .zero_req   (zero_req),
    .freeze_req (freeze_req),
    .step       (count)
  );

  // direct zero line acts on the edge it is seen (R5)
  assert_direct_zero_R5: assert property (@(posedge act_clk) disable iff (!rst_int_n)
    (clr_raw[0] && !clr_use_reg[0]) |=> (count == '0));
  // registered zero line acts one edge later (R6)
  assert_late_zero_R6: assert property (@(posedge act_clk) disable iff (!rst_int_n)
    (clr_raw[1] && clr_use_reg[1]) ##1 clr_use_reg[1] |=> (count == '0));
  // count held at zero while reset is applied (R8)
  assert_reset_zero_R8: assert property (@(posedge act_clk)
    !rst_n |-> (count == '0));
endmodule

// File: tb/seqgen_counter_test.sv
module seqgen_counter_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       edge_fall;
  logic [1:0] clr_raw, clr_use_reg, hold_raw, hold_use_reg;
  logic [5:0] count;
  int         tests = 0;
  int         fails = 0;

  always #4 clk = ~clk;   // 125 MHz

  seqgen_counter uut (
    .clk(clk), .rst_n(rst_n), .edge_fall(edge_fall),
    .clr_raw(clr_raw), .clr_use_reg(clr_use_reg),
    .hold_raw(hold_raw), .hold_use_reg(hold_use_reg),
    .count(count)
  );

  // entry: {req tag, clr_raw, clr_use_reg, hold_raw, hold_use_reg, expected count}
  localparam int NV = 23;
  localparam logic [17:0] VEC [NV] = '{
    {4'd1, 2'b00, 2'b00, 2'b00, 2'b00, 6'd1},  // R1
    {4'd1, 2'b00, 2'b00, 2'b00, 2'b00, 6'd2},
    {4'd1, 2'b00, 2'b00, 2'b00, 2'b00, 6'd3},
    {4'd3, 2'b00, 2'b00, 2'b01, 2'b00, 6'd3},  // R3 line 0
    {4'd3, 2'b00, 2'b00, 2'b10, 2'b00, 6'd3},  // R3 line 1
    {4'd1, 2'b00, 2'b00, 2'b00, 2'b00, 6'd4},
    {4'd2, 2'b01, 2'b00, 2'b00, 2'b00, 6'd0},  // R2 line 0
    {4'd1, 2'b00, 2'b00, 2'b00, 2'b00, 6'd1},
    {4'd2, 2'b10, 2'b00, 2'b00, 2'b00, 6'd0},  // R2 line 1
    {4'd1, 2'b00, 2'b00, 2'b00, 2'b00, 6'd1},
    {4'd4, 2'b01, 2'b00, 2'b10, 2'b00, 6'd0},  // R4
    {4'd1, 2'b00, 2'b00, 2'b00, 2'b00, 6'd1},
    {4'd6, 2'b01, 2'b01, 2'b00, 2'b00, 6'd2},  // R6 zero not yet
    {4'd6, 2'b00, 2'b01, 2'b00, 2'b00, 6'd0},  // R6 zero late
    {4'd6, 2'b00, 2'b01, 2'b00, 2'b00, 6'd1},
    {4'd6, 2'b00, 2'b00, 2'b10, 2'b10, 6'd2},  // R6 freeze not yet
    {4'd6, 2'b00, 2'b00, 2'b00, 2'b10, 6'd2},  // R6 freeze late
    {4'd6, 2'b00, 2'b00, 2'b00, 2'b10, 6'd3},
    {4'd5, 2'b10, 2'b01, 2'b00, 2'b00, 6'd0},  // R5 direct line 1
    {4'd5, 2'b00, 2'b01, 2'b00, 2'b00, 6'd1},  // R5 old value ignored
    {4'd6, 2'b00, 2'b00, 2'b01, 2'b01, 6'd2},
    {4'd6, 2'b00, 2'b00, 2'b00, 2'b01, 6'd2},
    {4'd1, 2'b00, 2'b00, 2'b00, 2'b00, 6'd3}
  };

  task automatic chk(input string req, input logic [5:0] exp);
    tests++;
    if (count !== exp) begin
      fails++;
      $display("FAIL %s: count=%0d expected=%0d", req, count, exp);
    end
  endtask

  task automatic quiet();
    if (edge_fall) @(posedge clk);
    else           @(negedge clk);
  endtask

  task automatic idle_in();
    clr_raw = '0; clr_use_reg = '0; hold_raw = '0; hold_use_reg = '0;
  endtask

  initial begin
    #(200000 * 8);
    tests++; fails++;
    $display("FAIL watchdog: count=%0d expected=finish", count);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [5:0] mid;
    rst_n = 1'b0; edge_fall = 1'b0; idle_in();
    repeat (2) @(negedge clk);
    chk("R8", 6'd0);
    rst_n = 1'b1;
    quiet(); quiet();
    chk("R8", 6'd0);   // still in synchronizer

    for (int k = 0; k < NV; k++) begin
      clr_raw      = VEC[k][13:12];
      clr_use_reg  = VEC[k][11:10];
      hold_raw     = VEC[k][9:8];
      hold_use_reg = VEC[k][7:6];
      quiet();
      chk($sformatf("R%0d step %0d", VEC[k][17:14], k), VEC[k][5:0]);
    end

    // R1 wrap
    idle_in();
    repeat (60) quiet();
    chk("R1 top", 6'd63);
    quiet();
    chk("R1 wrap", 6'd0);
    repeat (5) quiet();
    chk("R1", 6'd5);

    // R8: reset clears count and the captured freeze copy
    hold_raw = 2'b01; hold_use_reg = 2'b01;
    quiet();
    chk("R8 pre", 6'd6);
    rst_n = 1'b0; hold_raw = 2'b00;
    #1;
    chk("R8 async", 6'd0);
    quiet();
    rst_n = 1'b1;
    quiet(); quiet();
    chk("R8 sync", 6'd0);
    quiet();
    chk("R8 copy cleared", 6'd1);

    // R7 falling-edge mode
    rst_n = 1'b0; idle_in();
    edge_fall = 1'b1;
    @(posedge clk);
    rst_n = 1'b1;
    quiet(); quiet();
    chk("R7 sync", 6'd0);
    quiet();
    chk("R7 first", 6'd1);
    @(negedge clk); #1;
    chk("R7 falling", 6'd2);
    mid = count;
    @(posedge clk); #1;
    chk("R7 no rising", mid);
    clr_raw = 2'b10;
    quiet();
    chk("R7 R2 zero", 6'd0);
    clr_raw = 2'b00; hold_raw = 2'b01; hold_use_reg = 2'b01;
    quiet();
    chk("R7 R6 pass", 6'd1);
    hold_raw = 2'b00;
    quiet();
    chk("R7 R6 freeze", 6'd1);
    quiet();
    chk("R7 R6 resume", 6'd2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule